// File: doc/BRIEF.md
# Power-of-Two Residue Sieve Engine

The engine looks for the smallest positive exponent n at which 2^n mod p equals any one of nine candidate residues. A start strobe captures an odd modulus p (greater than one) and the nine candidates into internal registers. After that, one iteration runs on every clock cycle. Each iteration doubles a running residue, reduces it modulo p with at most one subtraction, and increments the exponent. The reduced value is compared against all nine candidates at the same time. The first equality ends the search and reports the exponent with a found flag.

If no candidate has matched after a parameterised number of iterations, the search ends with a result of zero. Several engines are meant to sit side by side behind a controller that hands out work. The operand width, the number of candidates and the iteration limit are all parameters. The defaults are 64 bits, nine candidates and fifty million iterations.

Top module: `pow2_residue_sieve`

## Requirements
- R1: On an accepted start (busy low), the modulus and all candidates are captured, the residue is set to 1 and the exponent to 0, and busy reads high from the next cycle.
- R2: The engine does one doubling step per clock cycle. A search that matches at exponent m raises done exactly m cycles after the clock edge that accepted start.
- R3: Each step doubles the residue into a value one bit wider and subtracts p at most once, so the residue stays below p and equals 2^n mod p. For p = 100003 with 96517 in a slot, the result is 9484.
- R4: The residue is compared with all candidate slots in parallel. Slot i is bits [i*WIDTH +: WIDTH] of the candidate bus. The reported exponent is the smallest n at which any slot matches, whichever slot that is.
- R5: A slot holding 0 or holding p never matches.
- R6: If no match occurs within LIMIT iterations, done pulses exactly LIMIT cycles after the start edge, with found low and exponent 0.
- R7: done is high for exactly one cycle. found and exponent keep their values until the next accepted start.
- R8: A start while busy is ignored. Changes to the modulus and candidate inputs during a search do not affect its result or its timing.
- R9: After reset, busy, done and found are low and exponent is 0.
- R10: found is low whenever the reported exponent is 0, and high with a non-zero exponent whenever a match was found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; accepted only while idle |
| modulus | input | WIDTH | Odd modulus p, greater than 1 |
| cand | input | NCAND*WIDTH | Candidate residues, slot i at bits [i*WIDTH +: WIDTH] |
| busy | output | 1 | A search is running |
| done | output | 1 | One-cycle pulse when a search ends |
| found | output | 1 | The last search found a match |
| exponent | output | $clog2(LIMIT+1) | Matching exponent, or 0 on exhaustion |

## Verification
A wrong residue shows up as a wrong exponent or a missing match. The match would land on a different cycle, or the search would run to the limit. So any step error is visible as both a wrong exponent value and a wrong done cycle, and the bench compares both against a software model. A counter that does not advance once per cycle shifts the done pulse even when the exponent value is right. A corrupted captured modulus or candidate after a stray start or an input change changes the result of that same search. The exhaustion path is only reached after LIMIT cycles, so the bench uses a small limit to see it.

// File: rtl/sieve_pkg.sv
package sieve_pkg;
   typedef enum logic {
      SV_IDLE = 1'b0,
      SV_RUN  = 1'b1
   } sieve_state_e;
endpackage

// File: rtl/mod_double.sv
// One modular doubling step: y = (2*r) mod m, given r < m.
module mod_double #(
   parameter int WIDTH = 64
) (
   input  logic [WIDTH-1:0] r,
   input  logic [WIDTH-1:0] m,
   output logic [WIDTH-1:0] y
);
   if (WIDTH < 2) begin : g_bad_width
      $error("mod_double: WIDTH must be at least 2");
   end

   logic [WIDTH:0] twice;
   logic [WIDTH:0] m_ext;
   logic [WIDTH:0] diff;

   always_comb begin
      twice = {r, 1'b0};
      m_ext = {1'b0, m};
      diff  = twice - m_ext;
      if (twice >= m_ext) y = diff[WIDTH-1:0];
      else                y = twice[WIDTH-1:0];
   end
endmodule

// File: rtl/residue_match.sv
// Parallel equality of one value against NCAND slots.
module residue_match #(
   parameter int WIDTH = 64,
   parameter int NCAND = 9
) (
   input  logic [WIDTH-1:0]       val,
   input  logic [NCAND*WIDTH-1:0] slots,
   output logic                   hit
);
   if (NCAND < 1) begin : g_bad_ncand
      $error("residue_match: NCAND must be at least 1");
   end

   logic [NCAND-1:0] eq;

   for (genvar i = 0; i < NCAND; i++) begin : g_slot
      assign eq[i] = (slots[i*WIDTH +: WIDTH] == val);
   end

   assign hit = |eq;
endmodule

// File: rtl/pow2_residue_sieve.sv
module pow2_residue_sieve
   import sieve_pkg::*;
#(
   parameter int WIDTH = 64,
   parameter int NCAND = 9,
   parameter int LIMIT = 50_000_000,
   localparam int CNT_W = $clog2(LIMIT + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [WIDTH-1:0]       modulus,
   input  logic [NCAND*WIDTH-1:0] cand,
   output logic                   busy,
   output logic                   done,
   output logic                   found,
   output logic [CNT_W-1:0]       exponent
);
   if (LIMIT < 1) begin : g_bad_limit
      $error("pow2_residue_sieve: LIMIT must be at least 1");
   end

   localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

   sieve_state_e           state_q;
   logic [WIDTH-1:0]       p_q;
   logic [NCAND*WIDTH-1:0] c_q;
   logic [WIDTH-1:0]       r_q;
   logic [WIDTH-1:0]       r_nx;
   logic [CNT_W-1:0]       n_q;
   logic [CNT_W-1:0]       n_nx;
   logic                   hit;

   mod_double #(.WIDTH(WIDTH)) dbl_i (
      .r (r_q),
      .m (p_q),
      .y (r_nx)
   );

   residue_match #(.WIDTH(WIDTH), .NCAND(NCAND)) cmp_i (
      .val   (r_nx),
      .slots (c_q),
      .hit   (hit)
   );

   assign n_nx = n_q + CNT_W'(1);
   assign busy = (state_q == SV_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SV_IDLE;
         p_q      <= '0;
         c_q      <= '0;
         r_q      <= '0;
         n_q      <= '0;
         done     <= 1'b0;
         found    <= 1'b0;
         exponent <= '0;
      end else begin
         done <= 1'b0;
         if (state_q == SV_IDLE) begin
            if (start) begin
               state_q  <= SV_RUN;
               p_q      <= modulus;
               c_q      <= cand;
               r_q      <= WIDTH'(1);
               n_q      <= '0;
               found    <= 1'b0;
               exponent <= '0;
            end
         end else begin
            r_q <= r_nx;
            n_q <= n_nx;
            if (hit) begin
               state_q  <= SV_IDLE;
               done     <= 1'b1;
               found    <= 1'b1;
               exponent <= n_nx;
            end else if (n_nx == LIM_V) begin
               state_q  <= SV_IDLE;
               done     <= 1'b1;
               found    <= 1'b0;
               exponent <= '0;
            end
         end
      end
   end

   // R3: running residue stays reduced below the captured modulus
   a_r3_residue_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (r_q < p_q));

   // R2: exponent advances by exactly one per running cycle
   a_r2_exp_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (n_q == $past(n_q) + CNT_W'(1)));

   // R6: a search never runs past its iteration limit
   a_r6_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (n_q < LIM_V));

   // R7: done is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: results hold while idle and no new start arrives
   a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(exponent) && $stable(found)));

   // R8: a start during a search leaves the captured modulus untouched
   a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (p_q == $past(p_q)));

   // R10: found implies a non-zero exponent
   a_r10_found_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (exponent != '0));
endmodule

// File: tb/pow2_residue_sieve_tb_top.sv
`timescale 1ns/1ps
module pow2_residue_sieve_tb_top;
   localparam int W     = 24;
   localparam int NC    = 9;
   localparam int LIM   = 12000;
   localparam int CW    = $clog2(LIM + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [W-1:0]      modulus = '0;
   logic [NC*W-1:0]   cand = '0;
   logic              busy, done, found;
   logic [CW-1:0]     exponent;

   int n_checks = 0;
   int n_fail   = 0;
   bit timed_out = 1'b0;

   always #10 clk = ~clk;

   pow2_residue_sieve #(.WIDTH(W), .NCAND(NC), .LIMIT(LIM)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .modulus(modulus),
      .cand(cand), .busy(busy), .done(done), .found(found),
      .exponent(exponent)
   );

   task automatic check(input bit ok, input string req, input longint act,
                        input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Reference: smallest n in 1..LIM with 2^n mod p in any slot, else 0.
   function automatic int model(input longint unsigned p,
                                input logic [NC*W-1:0] c);
      longint unsigned r = 1;
      for (int n = 1; n <= LIM; n++) begin
         r = r * 2;
         if (r >= p) r = r - p;
         for (int i = 0; i < NC; i++)
            if (r == longint'(c[i*W +: W])) return n;
      end
      return 0;
   endfunction

   function automatic longint unsigned pow2mod(input longint unsigned p,
                                               input int k);
      longint unsigned r = 1;
      for (int n = 1; n <= k; n++) begin
         r = r * 2;
         if (r >= p) r = r - p;
      end
      return r;
   endfunction

   // Runs one search; optionally disturbs inputs and pulses start mid-run.
   task automatic run_search(input longint unsigned p,
                             input logic [NC*W-1:0] c,
                             input bit disturb, input string tag);
      int exp_n;
      int cyc;
      exp_n = model(p, c);
      @(negedge clk);
      modulus = W'(p);
      cand    = c;
      start   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R1 busy after start", busy, 1);
      cyc = 0;
      while (done !== 1'b1 && !timed_out) begin
         @(posedge clk);
         @(negedge clk);
         cyc++;
         if (disturb && cyc == 3) begin
            start   = 1'b1;
            modulus = W'(p + 2);
            cand    = ~c;
         end
         if (disturb && cyc == 4) start = 1'b0;
      end
      start = 1'b0;
      check(int'(exponent) == exp_n, {tag, " exponent"}, exponent, exp_n);
      check(found === (exp_n != 0), {tag, " R10 found flag"}, found, exp_n != 0);
      check(cyc == ((exp_n != 0) ? exp_n : LIM), {tag, " R2 latency"},
            cyc, (exp_n != 0) ? exp_n : LIM);
      @(posedge clk);
      @(negedge clk);
      check(done === 1'b0, "R7 done one cycle", done, 0);
      check(int'(exponent) == exp_n && busy === 1'b0, "R7 result held",
            exponent, exp_n);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      timed_out = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
   end

   initial begin : stim
      logic [NC*W-1:0] c;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && done === 1'b0 && found === 1'b0,
            "R9 reset flags", {busy, done, found}, 0);
      check(exponent == '0, "R9 reset exponent", exponent, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: known case, other slots 0 (R5)
      c = '0;
      c[0 +: W] = W'(96517);
      check(model(100003, c) == 9484, "R3 model sanity", model(100003, c), 9484);
      run_search(100003, c, 1'b0, "R3 known case");

      // R4: two slots, the later slot holds the earlier exponent
      c = '0;
      c[0 +: W]     = W'(96517);
      c[8*W +: W]   = W'(pow2mod(100003, 50));
      check(model(100003, c) == 50, "R4 smallest exponent model", model(100003, c), 50);
      run_search(100003, c, 1'b0, "R4 lowest slot-independent");

      // R5/R6: slots only 0 or p -> exhaustion
      c = '0;
      for (int i = 0; i < NC; i += 2) c[i*W +: W] = W'(1021);
      run_search(1021, c, 1'b0, "R5 R6 exhaustion");

      // R8: start and input changes during a search are ignored
      c = '0;
      c[4*W +: W] = W'(pow2mod(7919, 200));
      run_search(7919, c, 1'b1, "R8 ignore start");

      // Random searches
      for (int t = 0; t < 20 && !timed_out; t++) begin
         longint unsigned p;
         int k;
         p = longint'($urandom_range(32'hFFFFF, 3)) | 1;
         k = $urandom_range(2500, 1);
         for (int i = 0; i < NC; i++) c[i*W +: W] = W'($urandom % p);
         c[$urandom_range(NC-1, 0)*W +: W] = W'(pow2mod(p, k));
         run_search(p, c, t[0], "R4 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
   end
endmodule